// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. A strobe `os_tick` runs at sixteen times the bit rate. The line passes through a synchronizer. A falling edge starts a candidate frame, and the block confirms that start bit near its middle. It then takes one sample per bit period at the nominal bit centre, least significant bit first. The frame carries the programmed number of data bits (5 to 8), an optional parity bit, and one stop bit, which is the only stop bit checked.

Each finished frame produces a one-cycle write strobe for a downstream holding FIFO. The strobe carries the data byte and three flags: parity error, framing error and line break. A frame that is low from start to stop is reported as a break. The receiver then waits for the line to be high for a minimum number of clock cycles before it looks for a new start edge.

If a frame that held some high bit ends with a low stop bit and the line is still low half a bit later, that instant counts as a new start edge.

The states are:

| State | Purpose and exits |
|---|---|
| HUNT | Waits for a falling edge. The edge moves it to START. |
| START | After 8 ticks the line is sampled. High goes back to HUNT; low goes to DATA. |
| DATA | Takes one sample every 16 ticks. After the last data bit it goes to PAR if parity is enabled, otherwise to STOP. |
| PAR | Takes the parity sample, then goes to STOP. |
| STOP | Takes the stop sample and fires the strobe. A high stop bit goes to HUNT with no gap. A low stop bit goes to BRKWAIT if every sample was low, otherwise to REARM. |
| REARM | After 8 ticks the line is sampled. Low goes to START; high goes to HUNT. |
| BRKWAIT | Goes to HUNT once the line has been high long enough. |

A low `rx_en` forces HUNT from any state.

Top module: `async_char_rx`

## Requirements
- R1: After reset `chr_wr`, `chr_data`, `chr_perr`, `chr_ferr` and `chr_brk` are all zero.
- R2: A low pulse that is high again when sampled 8 ticks after its falling edge is discarded: no strobe, and hunting resumes.
- R3: Data bits are sampled once per 16 ticks, and the first bit received lands in `chr_data[0]`.
- R4: `char_len` selects the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bits of `chr_data` above that length are zero.
- R5: `par_mode` 01 selects even parity and 10 selects odd parity; 00 and 11 mean no parity bit. `chr_perr` is set when the data bits plus the parity bit fail the selected rule, and it is never set when parity is off.
- R6: A low stop bit sets `chr_ferr`, and the character is still delivered. Only one stop bit is checked.
- R7: A frame that is low in every sample, stop included, delivers `chr_data` = 0 with `chr_brk` = 1, `chr_ferr` = 0 and `chr_perr` = 0.
- R8: After a break, hunting resumes only after the synchronized line has been high for 2 consecutive clocks. A single high clock is ignored.
- R9: After a framing error on a frame that is not a break, a line still low 8 ticks after the stop sample acts as a new start edge.
- R10: After a high stop bit, a start edge that follows at once is received with no idle time required.
- R11: While `rx_en` is low the receiver stays idle and issues no strobe.
- R12: `chr_wr` is high for exactly one clock per character, and data and flags are valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-clock enable at 16 times the bit rate |
| rx_en | input | 1 | Receiver enable |
| char_len | input | 2 | Data length code (5 to 8 bits) |
| par_mode | input | 2 | Parity selection |
| rxd | input | 1 | Asynchronous serial line, idle high |
| chr_wr | output | 1 | Character write strobe |
| chr_data | output | 8 | Received character |
| chr_perr | output | 1 | Parity error for this character |
| chr_ferr | output | 1 | Framing error for this character |
| chr_brk | output | 1 | Break detected for this character |

## Verification
The hardest situation to reach is the one where a framing error runs straight into the next character without the line ever going high. Here the only start reference is the re-arm sample half a bit after the stop sample. The bench drives a low stop bit and follows it at once with the low start bit of a second frame. Both characters must come back correct.

The break exit is reached in a similar way. Without returning the line high, the bench drives pulses one clock and two clocks wide after a long break. It then checks that only the wider pulse lets a new, all-low frame be taken.

// File: rtl/rx_pkg.sv
package rx_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_REARM,
        ST_BRKWAIT
    } rx_state_e;

    localparam logic [1:0] PAR_EVEN = 2'b01;
    localparam logic [1:0] PAR_ODD  = 2'b10;

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], din};
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/rx_tick_cnt.sv
module rx_tick_cnt #(
    parameter int OS_RATE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic half_hit,
    output logic full_hit
);
    localparam int CW   = $clog2(OS_RATE);
    localparam int HALF = OS_RATE / 2;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (tick)
            cnt <= (cnt == CW'(OS_RATE - 1)) ? '0 : cnt + 1'b1;
    end

    assign half_hit = tick && (cnt == CW'(HALF - 1));
    assign full_hit = tick && (cnt == CW'(OS_RATE - 1));
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter #(
    parameter int CHAR_MAX = 8,
    parameter int LW       = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                take_data,
    input  logic                take_par,
    input  logic                bit_in,
    input  logic [LW-1:0]       len_code,
    output logic [CHAR_MAX-1:0] data,
    output logic                last_data,
    output logic                par_xor,
    output logic                par_bit,
    output logic                any_high
);
    localparam int IW       = $clog2(CHAR_MAX);
    localparam int MIN_LAST = CHAR_MAX - (1 << LW);

    logic [IW-1:0] idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data     <= '0;
            idx      <= '0;
            par_bit  <= 1'b0;
            any_high <= 1'b0;
        end else if (clr) begin
            data     <= '0;
            idx      <= '0;
            par_bit  <= 1'b0;
            any_high <= 1'b0;
        end else if (take_data) begin
            data[idx] <= bit_in;
            idx       <= idx + 1'b1;
            any_high  <= any_high | bit_in;
        end else if (take_par) begin
            par_bit  <= bit_in;
            any_high <= any_high | bit_in;
        end
    end

    assign last_data = (idx == IW'(len_code) + IW'(MIN_LAST));
    assign par_xor   = ^data;
endmodule

// File: rtl/rx_brk_filter.sv
module rx_brk_filter #(
    parameter int MIN_HIGH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic line,
    output logic done
);
    localparam int HW = $clog2(MIN_HIGH + 1);

    logic [HW-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run <= '0;
        else if (!en || !line)
            run <= '0;
        else if (run != HW'(MIN_HIGH - 1))
            run <= run + 1'b1;
    end

    assign done = en && line && (run == HW'(MIN_HIGH - 1));
endmodule

// File: rtl/async_char_rx.sv
module async_char_rx #(
    parameter int OS_RATE      = 16,
    parameter int CHAR_MAX     = 8,
    parameter int SYNC_STAGES  = 2,
    parameter int BRK_MIN_HIGH = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                os_tick,
    input  logic                rx_en,
    input  logic [1:0]          char_len,
    input  logic [1:0]          par_mode,
    input  logic                rxd,
    output logic                chr_wr,
    output logic [CHAR_MAX-1:0] chr_data,
    output logic                chr_perr,
    output logic                chr_ferr,
    output logic                chr_brk
);
    import rx_pkg::*;

    rx_state_e state, nxt;

    logic rxd_s, rxd_p, fall;
    logic cnt_clr, half_hit, full_hit;
    logic sh_clr, take_data, take_par, fire;
    logic [CHAR_MAX-1:0] sh_data;
    logic last_data, par_xor, par_bit, any_high;
    logic brk_done, brk_now, par_on;
    logic [1:0] len_lat, par_lat;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxd_s)
    );

    rx_tick_cnt #(.OS_RATE(OS_RATE)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tick(os_tick),
        .half_hit(half_hit), .full_hit(full_hit)
    );

    rx_shifter #(.CHAR_MAX(CHAR_MAX), .LW(2)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(sh_clr), .take_data(take_data),
        .take_par(take_par), .bit_in(rxd_s), .len_code(len_lat),
        .data(sh_data), .last_data(last_data), .par_xor(par_xor),
        .par_bit(par_bit), .any_high(any_high)
    );

    rx_brk_filter #(.MIN_HIGH(BRK_MIN_HIGH)) u_brk (
        .clk(clk), .rst_n(rst_n), .en(state == ST_BRKWAIT),
        .line(rxd_s), .done(brk_done)
    );

    assign fall    = rxd_p && !rxd_s;
    assign par_on  = (par_lat == PAR_EVEN) || (par_lat == PAR_ODD);
    assign brk_now = !any_high && !rxd_s;

    // next-state and datapath controls
    always_comb begin
        nxt       = state;
        cnt_clr   = 1'b0;
        sh_clr    = 1'b0;
        take_data = 1'b0;
        take_par  = 1'b0;
        fire      = 1'b0;
        if (!rx_en) begin
            nxt = ST_HUNT;
        end else begin
            unique case (state)
                ST_HUNT: begin
                    if (fall) begin
                        nxt     = ST_START;
                        cnt_clr = 1'b1;
                    end
                end
                ST_START: begin
                    if (half_hit) begin
                        cnt_clr = 1'b1;
                        sh_clr  = 1'b1;
                        nxt     = rxd_s ? ST_HUNT : ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (full_hit) begin
                        cnt_clr   = 1'b1;
                        take_data = 1'b1;
                        if (last_data) nxt = par_on ? ST_PAR : ST_STOP;
                    end
                end
                ST_PAR: begin
                    if (full_hit) begin
                        cnt_clr  = 1'b1;
                        take_par = 1'b1;
                        nxt      = ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (full_hit) begin
                        cnt_clr = 1'b1;
                        fire    = 1'b1;
                        if (rxd_s)          nxt = ST_HUNT;
                        else if (!any_high) nxt = ST_BRKWAIT;
                        else                nxt = ST_REARM;
                    end
                end
                ST_REARM: begin
                    if (half_hit) begin
                        cnt_clr = 1'b1;
                        nxt     = rxd_s ? ST_HUNT : ST_START;
                    end
                end
                ST_BRKWAIT: begin
                    if (brk_done) nxt = ST_HUNT;
                end
                default: nxt = ST_HUNT;
            endcase
        end
    end

    // state register, line history and per-frame configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_HUNT;
            rxd_p   <= 1'b0;
            len_lat <= 2'b11;
            par_lat <= 2'b00;
        end else begin
            state <= nxt;
            rxd_p <= rxd_s;
            if (nxt == ST_START && state != ST_START) begin
                len_lat <= char_len;
                par_lat <= par_mode;
            end
        end
    end

    // character outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chr_wr   <= 1'b0;
            chr_data <= '0;
            chr_perr <= 1'b0;
            chr_ferr <= 1'b0;
            chr_brk  <= 1'b0;
        end else begin
            chr_wr <= fire;
            if (fire) begin
                chr_data <= brk_now ? '0 : sh_data;
                chr_brk  <= brk_now;
                chr_ferr <= !rxd_s && !brk_now;
                chr_perr <= par_on && !brk_now && (par_xor ^ par_bit ^ par_lat[1]);
            end
        end
    end
endmodule

// File: rtl/async_char_rx_chk.sv
module async_char_rx_chk #(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic              chr_wr,
    input logic [W-1:0]      chr_data,
    input logic              chr_perr,
    input logic              chr_ferr,
    input logic              chr_brk,
    input rx_pkg::rx_state_e st,
    input logic              rxd_s,
    input logic [1:0]        par_lat,
    input logic [1:0]        len_lat
);
    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        chr_wr |=> !chr_wr); // R12

    AST_BRK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_wr && chr_brk) |-> (chr_data == '0 && !chr_ferr && !chr_perr)); // R7

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !chr_wr); // R11

    AST_NOPAR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_wr && !(par_lat == 2'b01 || par_lat == 2'b10)) |-> !chr_perr); // R5

    AST_SHORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_wr && len_lat == 2'b00) |-> (chr_data[W-1:W-3] == '0)); // R4

    AST_BRK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && st == rx_pkg::ST_BRKWAIT && !rxd_s) |=> (st == rx_pkg::ST_BRKWAIT)); // R8
endmodule

bind async_char_rx async_char_rx_chk #(.W(CHAR_MAX)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .chr_wr(chr_wr),
    .chr_data(chr_data), .chr_perr(chr_perr), .chr_ferr(chr_ferr),
    .chr_brk(chr_brk), .st(state), .rxd_s(rxd_s),
    .par_lat(par_lat), .len_lat(len_lat)
);

// File: tb/async_char_rx_bench.sv
module async_char_rx_bench;
    localparam int TICK_CLKS = 4;
    localparam int NV        = 14;

    typedef struct packed {
        logic [1:0] lc;
        logic [1:0] pm;
        logic [7:0] d;
        logic       flip;
        logic       stopv;
        logic [7:0] exd;
        logic       ep;
        logic       ef;
        logic       eb;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{2'd3, 2'd0, 8'hA5, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0},
        '{2'd3, 2'd1, 8'h3C, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b0, 1'b0},
        '{2'd3, 2'd2, 8'h3C, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b0, 1'b0},
        '{2'd3, 2'd1, 8'h3C, 1'b1, 1'b1, 8'h3C, 1'b1, 1'b0, 1'b0},
        '{2'd0, 2'd0, 8'hFF, 1'b0, 1'b1, 8'h1F, 1'b0, 1'b0, 1'b0},
        '{2'd1, 2'd2, 8'h2A, 1'b0, 1'b1, 8'h2A, 1'b0, 1'b0, 1'b0},
        '{2'd2, 2'd1, 8'h55, 1'b1, 1'b1, 8'h55, 1'b1, 1'b0, 1'b0},
        '{2'd3, 2'd0, 8'h81, 1'b0, 1'b0, 8'h81, 1'b0, 1'b1, 1'b0},
        '{2'd0, 2'd1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1},
        '{2'd3, 2'd0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1},
        '{2'd3, 2'd2, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0},
        '{2'd1, 2'd1, 8'h3F, 1'b0, 1'b1, 8'h3F, 1'b0, 1'b0, 1'b0},
        '{2'd2, 2'd2, 8'h7F, 1'b1, 1'b0, 8'h7F, 1'b1, 1'b1, 1'b0},
        '{2'd0, 2'd2, 8'hE3, 1'b0, 1'b1, 8'h03, 1'b0, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_en = 1'b1;
    logic [1:0] char_len = 2'd3;
    logic [1:0] par_mode = 2'd0;
    logic       rxd = 1'b1;
    logic       chr_wr;
    logic [7:0] chr_data;
    logic       chr_perr, chr_ferr, chr_brk;

    int vec_n = 0;
    int bad_n = 0;
    logic [1:0] tdiv = 2'd0;

    logic [10:0] cap_q [0:63];
    int   cap_n  = 0;
    int   wide_n = 0;
    logic wr_seen = 1'b0;

    always #5 clk = ~clk;

    always @(negedge clk) begin
        tdiv    <= tdiv + 2'd1;
        os_tick <= (tdiv == 2'd3);
    end

    always @(negedge clk) begin
        if (chr_wr) begin
            cap_q[cap_n[5:0]] <= {chr_data, chr_perr, chr_ferr, chr_brk};
            cap_n <= cap_n + 1;
        end
        if (chr_wr && wr_seen) wide_n <= wide_n + 1;
        wr_seen <= chr_wr;
    end

    async_char_rx u_async_char_rx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_en(rx_en),
        .char_len(char_len), .par_mode(par_mode), .rxd(rxd),
        .chr_wr(chr_wr), .chr_data(chr_data), .chr_perr(chr_perr),
        .chr_ferr(chr_ferr), .chr_brk(chr_brk)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vec_n++;
        if (got !== exp) begin
            bad_n++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic hold(input logic v, input int ticks);
        rxd = v;
        repeat (ticks * TICK_CLKS) @(negedge clk);
    endtask

    task automatic send_body(input logic [1:0] lc, input logic [1:0] pm,
                             input logic [7:0] d, input logic flip);
        logic [7:0] mask;
        logic p;
        mask = 8'hFF >> (3 - lc);
        char_len = lc;
        par_mode = pm;
        hold(1'b0, 16);
        for (int i = 0; i < lc + 5; i++) hold(d[i], 16);
        if (pm == 2'd1 || pm == 2'd2) begin
            p = (^(d & mask)) ^ (pm == 2'd2) ^ flip;
            hold(p, 16);
        end
    endtask

    task automatic expect_cap(input string tag, input int idx, input logic [10:0] exp);
        check(tag, {21'd0, cap_q[idx[5:0]]}, {21'd0, exp});
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        check("R1 strobe in reset", {31'd0, chr_wr}, 32'd0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check("R1 strobe after reset", {31'd0, chr_wr}, 32'd0);
        check("R1 outputs after reset", {21'd0, chr_data, chr_perr, chr_ferr, chr_brk}, 32'd0);
        hold(1'b1, 20);

        for (int i = 0; i < NV; i++) begin
            base = cap_n;
            send_body(VECS[i].lc, VECS[i].pm, VECS[i].d, VECS[i].flip);
            if (VECS[i].stopv) hold(1'b1, 16);
            else hold(1'b0, 12);
            hold(1'b1, 32);
            check($sformatf("R12 vec %0d one strobe", i), cap_n - base, 32'd1);
            check($sformatf("R3 R4 vec %0d data", i), {24'd0, cap_q[base[5:0]][10:3]}, {24'd0, VECS[i].exd});
            check($sformatf("R5 vec %0d perr", i), {31'd0, cap_q[base[5:0]][2]}, {31'd0, VECS[i].ep});
            check($sformatf("R6 vec %0d ferr", i), {31'd0, cap_q[base[5:0]][1]}, {31'd0, VECS[i].ef});
            check($sformatf("R7 vec %0d brk", i), {31'd0, cap_q[base[5:0]][0]}, {31'd0, VECS[i].eb});
        end

        // R2: short low pulse is a false start
        base = cap_n;
        hold(1'b0, 5);
        hold(1'b1, 40);
        check("R2 false start no strobe", cap_n - base, 32'd0);
        send_body(2'd3, 2'd0, 8'h96, 1'b0);
        hold(1'b1, 32);
        check("R2 hunt resumes count", cap_n - base, 32'd1);
        expect_cap("R2 hunt resumes data", base, {8'h96, 3'b000});

        // R10 / R6: back-to-back frames, single stop bit
        base = cap_n;
        send_body(2'd3, 2'd0, 8'h12, 1'b0);
        hold(1'b1, 16);
        send_body(2'd3, 2'd0, 8'h34, 1'b0);
        hold(1'b1, 32);
        check("R10 back-to-back count", cap_n - base, 32'd2);
        expect_cap("R10 first", base, {8'h12, 3'b000});
        expect_cap("R10 second", base + 1, {8'h34, 3'b000});

        // R9: framing error followed by a low line re-arms
        base = cap_n;
        send_body(2'd3, 2'd0, 8'h0F, 1'b0);
        hold(1'b0, 16);
        send_body(2'd3, 2'd0, 8'h5A, 1'b0);
        hold(1'b1, 48);
        check("R9 rearm count", cap_n - base, 32'd2);
        expect_cap("R9 ferr char", base, {8'h0F, 3'b010});
        expect_cap("R9 rearmed char", base + 1, {8'h5A, 3'b000});

        // R8: break exit needs two high clocks
        base = cap_n;
        send_body(2'd3, 2'd0, 8'h00, 1'b0);
        hold(1'b0, 36);
        check("R8 break seen", cap_n - base, 32'd1);
        expect_cap("R8 break flags", base, {8'h00, 3'b001});
        rxd = 1'b1;
        @(negedge clk);
        hold(1'b0, 16 * 12);
        check("R8 one-clock high ignored", cap_n - base, 32'd1);
        rxd = 1'b1;
        repeat (2) @(negedge clk);
        hold(1'b0, 16 * 12);
        check("R8 two-clock high ends break", cap_n - base, 32'd2);
        expect_cap("R8 second break", base + 1, {8'h00, 3'b001});
        hold(1'b1, 32);
        send_body(2'd3, 2'd0, 8'hC3, 1'b0);
        hold(1'b1, 32);
        check("R8 normal after break", cap_n - base, 32'd3);
        expect_cap("R8 normal data", base + 2, {8'hC3, 3'b000});

        // R11: disabled receiver is idle
        base = cap_n;
        rx_en = 1'b0;
        send_body(2'd3, 2'd0, 8'hA5, 1'b0);
        hold(1'b1, 32);
        check("R11 disabled no strobe", cap_n - base, 32'd0);
        rx_en = 1'b1;
        hold(1'b1, 8);
        send_body(2'd3, 2'd0, 8'h5A, 1'b0);
        hold(1'b1, 32);
        check("R11 enabled again", cap_n - base, 32'd1);
        expect_cap("R11 data", base, {8'h5A, 3'b000});

        check("R12 strobe width", wide_n, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad_n++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
        $finish;
    end
endmodule